// File: doc/BRIEF.md
# Consumer IR run-length receiver

This block watches the output of an infrared receiver module and turns the waveform into a stream of run-length symbols. The input is resynchronised, optionally inverted, and sampled at a rate derived from the IR base clock divided by 64 or by 128. A sample-count glitch filter absorbs short runs into the run before them. Each accepted run is stored as an 8-bit symbol in a receive FIFO: one bit for the level and seven bits for the length in sample periods. Runs longer than the 7-bit range are split. A packet opens at the first pulse and closes when the line has stayed in space long enough to reach a programmable idle limit.

Software drives the block through a small word-addressed register port: control, receive configuration, sample configuration, interrupt enable, status, and a data word whose read pops the FIFO. Three sticky status events exist: overflow, packet end, and data above a programmed level. They are cleared by writing ones, and each can drive the single interrupt line.

Top module: `cir_rx_top`

## Requirements
- R1: After reset, every register reads zero (CTRL=0, RXCFG=1, DATA=2, IEN=3, STAT=4, SCFG=5, word address on reg_addr), and irq is low.
- R2: Each symbol is 8 bits: bit 7 is the level (1 = pulse, 0 = space) and bits 6:0 are the run length in sample periods. Capture starts at the first pulse. The sample period is 64 IR clocks when SCFG bit 0 is 0 and 128 when it is 1.
- R3: A run longer than 127 samples produces symbols of length 127 until the remainder, at the same level, is 127 or less.
- R4: A run shorter than the SCFG[7:2] threshold, in samples, is not a level change. It adds to the length of the run before it.
- R5: When a space inside a packet lasts (SCFG[15:8]+1)*128 samples, STAT bit 1 is set and the packet closes. Chunks of 127 emitted before that point stay in the FIFO. The unfinished remainder of that space is not stored.
- R6: RXCFG bit 2 inverts the input. With it set, a low input is a pulse.
- R7: Capture runs only while CTRL bit 0 (global enable) and bit 1 (receive enable) are both 1 and CTRL[5:4] is 2'b11. Otherwise no symbol is stored and no packet end is raised.
- R8: Reading DATA pops the oldest symbol into reg_rdata[7:0]. It returns zero when the FIFO is empty. STAT[8+:5] gives the number of stored symbols (FIFO depth 16).
- R9: A symbol that arrives while the FIFO is full is dropped, and STAT bit 0 is set.
- R10: STAT bit 4 is set while the stored count is greater than the IEN[11:8] level. STAT bits 0, 1 and 4 stay set until a 1 is written to the same bit of STAT.
- R11: irq is high exactly when some STAT bit among 0, 1 and 4 is set together with the same bit of IEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | IR base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw receiver output |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; the data appears on the next cycle |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a packet that overflows the FIFO while the data-level event sits exactly at its threshold. Reaching it takes a long, dense pulse train, then a careful drain down to the programmed level before the sticky bit is cleared. The bench builds such a train and pops entries until exactly the level count remains. It then clears and rereads the status to show the event does not reassert. Long-run splitting that meets an idle limit above the minimum is reached with a 254-sample space inside the packet and a 300-sample trailing space. A behavioural model of merge, split and timeout predicts every popped symbol.

// File: rtl/cir_rx_pkg.sv
package cir_rx_pkg;
  typedef struct packed {
    logic       lvl;
    logic [6:0] len;
  } sym_t;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_RXCFG = 3'd1;
  localparam logic [2:0] A_DATA  = 3'd2;
  localparam logic [2:0] A_IEN   = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;
  localparam logic [2:0] A_SCFG  = 3'd5;

  localparam int B_OVF   = 0;
  localparam int B_PEND  = 1;
  localparam int B_AVAIL = 4;
  localparam int B_FIELD = 8;

  localparam logic [6:0] RUN_MAX = 7'd127;
endpackage

// File: rtl/cir_rx_front.sv
module cir_rx_front #(
  parameter int BASE_DIV = 1,
  parameter int FILT_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ir_in,
  input  logic              invert,
  input  logic              div_sel,
  input  logic [FILT_W-1:0] filt_thr,
  output logic              tick,
  output logic              lvl
);
  localparam int PRE_W = $clog2(128 * BASE_DIV);
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(128 * BASE_DIV - 1);
  localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(64 * BASE_DIV - 1);

  logic [1:0]        sync_q;
  logic              raw;
  logic [PRE_W-1:0]  pre_q, pre_n, lim;
  logic              flt_q, flt_n;
  logic [FILT_W-1:0] dif_q, dif_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ir_in};
  end

  assign raw  = sync_q[1] ^ invert;
  assign lim  = div_sel ? LIM_SLOW : LIM_FAST;
  assign tick = run && (pre_q >= lim);
  assign lvl  = flt_q;

  always_comb begin
    pre_n = pre_q;
    flt_n = flt_q;
    dif_n = dif_q;
    if (!run) begin
      pre_n = '0;
      flt_n = 1'b0;
      dif_n = '0;
    end else begin
      pre_n = tick ? '0 : pre_q + PRE_W'(1);
      if (tick) begin
        if (raw == flt_q) begin
          dif_n = '0;
        end else if (({1'b0, dif_q} + (FILT_W+1)'(1)) >= {1'b0, filt_thr}) begin
          flt_n = raw;
          dif_n = '0;
        end else begin
          dif_n = dif_q + FILT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      flt_q <= 1'b0;
      dif_q <= '0;
    end else begin
      pre_q <= pre_n;
      flt_q <= flt_n;
      dif_q <= dif_n;
    end
  end
endmodule

// File: rtl/cir_rx_coder.sv
module cir_rx_coder
  import cir_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       lvl,
  input  logic [7:0] idle_thr,
  output logic       push,
  output sym_t       sym,
  output logic       pkt_end
);
  logic        act_q, act_n, cur_q, cur_n;
  logic [6:0]  cnt_q, cnt_n;
  logic [15:0] idl_q, idl_n;
  logic [16:0] idl_lim, idl_inc;

  assign idl_lim = ({9'd0, idle_thr} + 17'd1) << 7;
  assign idl_inc = {1'b0, idl_q} + 17'd1;
  assign sym     = '{lvl: cur_q, len: cnt_q};

  always_comb begin
    act_n   = act_q;
    cur_n   = cur_q;
    cnt_n   = cnt_q;
    idl_n   = idl_q;
    push    = 1'b0;
    pkt_end = 1'b0;
    if (!run) begin
      act_n = 1'b0;
      cur_n = 1'b0;
      cnt_n = '0;
      idl_n = '0;
    end else if (tick) begin
      if (!act_q) begin
        if (lvl) begin
          act_n = 1'b1;
          cur_n = 1'b1;
          cnt_n = 7'd1;
          idl_n = '0;
        end
      end else if (lvl != cur_q) begin
        push  = 1'b1;
        cur_n = lvl;
        cnt_n = 7'd1;
        idl_n = lvl ? 16'd0 : 16'd1;
      end else if (!cur_q && (idl_inc == idl_lim)) begin
        pkt_end = 1'b1;
        act_n   = 1'b0;
        cnt_n   = '0;
        idl_n   = '0;
      end else begin
        if (cnt_q == RUN_MAX) begin
          push  = 1'b1;
          cnt_n = 7'd1;
        end else begin
          cnt_n = cnt_q + 7'd1;
        end
        if (!cur_q) idl_n = idl_inc[15:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cur_q <= 1'b0;
      cnt_q <= '0;
      idl_q <= '0;
    end else begin
      act_q <= act_n;
      cur_q <= cur_n;
      cnt_q <= cnt_n;
      idl_q <= idl_n;
    end
  end
endmodule

// File: rtl/cir_rx_fifo.sv
module cir_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign do_push = push && (!full || do_pop);
  assign drop    = push && full && !do_pop;
  assign dout    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + AW'(1);
      if (do_pop)  rp_q <= rp_q + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/cir_rx_top.sv
module cir_rx_top
  import cir_rx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int BASE_DIV = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic rs_q1, rs_q2, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs_q2, rs_q1} <= 2'b00;
    else        {rs_q2, rs_q1} <= {rs_q1, 1'b1};
  end
  assign rst_i = rs_q2;

  // register state
  logic          ctl_gen, ctl_rxen, cfg_inv, smp_div;
  logic [1:0]    ctl_mode;
  logic          ien_ovf, ien_pend, ien_avail;
  logic [AW-1:0] ien_lvl;
  logic [5:0]    smp_filt;
  logic [7:0]    smp_idle;
  logic          st_ovf, st_pend, st_avail;
  logic          ctl_gen_n, ctl_rxen_n, cfg_inv_n, smp_div_n;
  logic [1:0]    ctl_mode_n;
  logic          ien_ovf_n, ien_pend_n, ien_avail_n;
  logic [AW-1:0] ien_lvl_n;
  logic [5:0]    smp_filt_n;
  logic [7:0]    smp_idle_n;
  logic          st_ovf_n, st_pend_n, st_avail_n;
  logic [31:0]   rdata_n;

  logic          run, tick, flt_lvl, coder_push, pkt_end;
  sym_t          coder_sym;
  logic          fifo_pop, fifo_full, fifo_drop, avail_cond;
  logic [7:0]    fifo_dout;
  logic [CW-1:0] fifo_count;
  logic          w_ctrl, w_rxcfg, w_ien, w_stat, w_scfg;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata[31:16];
  assign run = ctl_gen && ctl_rxen && (ctl_mode == 2'b11);

  cir_rx_front #(.BASE_DIV(BASE_DIV), .FILT_W(6)) u_front (
    .clk(clk), .rst_n(rst_i), .run(run), .ir_in(ir_in), .invert(cfg_inv),
    .div_sel(smp_div), .filt_thr(smp_filt), .tick(tick), .lvl(flt_lvl));

  cir_rx_coder u_coder (
    .clk(clk), .rst_n(rst_i), .run(run), .tick(tick), .lvl(flt_lvl),
    .idle_thr(smp_idle), .push(coder_push), .sym(coder_sym), .pkt_end(pkt_end));

  cir_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_i), .push(coder_push), .din(coder_sym),
    .pop(fifo_pop), .dout(fifo_dout), .count(fifo_count),
    .full(fifo_full), .drop(fifo_drop));

  assign w_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign w_rxcfg  = reg_wr && (reg_addr == A_RXCFG);
  assign w_ien    = reg_wr && (reg_addr == A_IEN);
  assign w_stat   = reg_wr && (reg_addr == A_STAT);
  assign w_scfg   = reg_wr && (reg_addr == A_SCFG);
  assign fifo_pop = reg_rd && (reg_addr == A_DATA);
  assign avail_cond = fifo_count > CW'(ien_lvl);

  always_comb begin
    ctl_gen_n   = w_ctrl  ? reg_wdata[0]    : ctl_gen;
    ctl_rxen_n  = w_ctrl  ? reg_wdata[1]    : ctl_rxen;
    ctl_mode_n  = w_ctrl  ? reg_wdata[5:4]  : ctl_mode;
    cfg_inv_n   = w_rxcfg ? reg_wdata[2]    : cfg_inv;
    ien_ovf_n   = w_ien   ? reg_wdata[B_OVF]   : ien_ovf;
    ien_pend_n  = w_ien   ? reg_wdata[B_PEND]  : ien_pend;
    ien_avail_n = w_ien   ? reg_wdata[B_AVAIL] : ien_avail;
    ien_lvl_n   = w_ien   ? reg_wdata[B_FIELD +: AW] : ien_lvl;
    smp_div_n   = w_scfg  ? reg_wdata[0]    : smp_div;
    smp_filt_n  = w_scfg  ? reg_wdata[7:2]  : smp_filt;
    smp_idle_n  = w_scfg  ? reg_wdata[15:8] : smp_idle;
    st_ovf_n    = fifo_drop  || (st_ovf   && !(w_stat && reg_wdata[B_OVF]));
    st_pend_n   = pkt_end    || (st_pend  && !(w_stat && reg_wdata[B_PEND]));
    st_avail_n  = avail_cond || (st_avail && !(w_stat && reg_wdata[B_AVAIL]));
    rdata_n = '0;
    case (reg_addr)
      A_CTRL:  rdata_n = {26'd0, ctl_mode, 2'b00, ctl_rxen, ctl_gen};
      A_RXCFG: rdata_n = {29'd0, cfg_inv, 2'b00};
      A_DATA:  rdata_n = (fifo_count != '0) ? {24'd0, fifo_dout} : 32'd0;
      A_IEN: begin
        rdata_n[B_FIELD +: AW] = ien_lvl;
        rdata_n[B_OVF]   = ien_ovf;
        rdata_n[B_PEND]  = ien_pend;
        rdata_n[B_AVAIL] = ien_avail;
      end
      A_STAT: begin
        rdata_n[B_FIELD +: CW] = fifo_count;
        rdata_n[B_OVF]   = st_ovf;
        rdata_n[B_PEND]  = st_pend;
        rdata_n[B_AVAIL] = st_avail;
      end
      A_SCFG:  rdata_n = {16'd0, smp_idle, smp_filt, 1'b0, smp_div};
      default: rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctl_gen <= 1'b0;  ctl_rxen <= 1'b0;  ctl_mode <= '0;  cfg_inv <= 1'b0;
      ien_ovf <= 1'b0;  ien_pend <= 1'b0;  ien_avail <= 1'b0; ien_lvl <= '0;
      smp_div <= 1'b0;  smp_filt <= '0;    smp_idle <= '0;
      st_ovf  <= 1'b0;  st_pend  <= 1'b0;  st_avail <= 1'b0;
      reg_rdata <= '0;
    end else begin
      ctl_gen <= ctl_gen_n;  ctl_rxen <= ctl_rxen_n;  ctl_mode <= ctl_mode_n;
      cfg_inv <= cfg_inv_n;
      ien_ovf <= ien_ovf_n;  ien_pend <= ien_pend_n;  ien_avail <= ien_avail_n;
      ien_lvl <= ien_lvl_n;
      smp_div <= smp_div_n;  smp_filt <= smp_filt_n;  smp_idle <= smp_idle_n;
      st_ovf  <= st_ovf_n;   st_pend  <= st_pend_n;   st_avail <= st_avail_n;
      if (reg_rd) reg_rdata <= rdata_n;
    end
  end

  assign irq = (st_ovf && ien_ovf) || (st_pend && ien_pend) || (st_avail && ien_avail);
endmodule

// File: rtl/cir_rx_chk.sv
module cir_rx_chk #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          push,
  input logic          pop,
  input logic          full,
  input logic          pkt_end,
  input logic [CW-1:0] count,
  input logic [6:0]    sym_len,
  input logic          st_ovf,
  input logic          st_pend,
  input logic          st_avail,
  input logic [2:0]    ien_bits,
  input logic [AW-1:0] ien_lvl,
  input logic          irq
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R8

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count != '0) |=> (count == $past(count) - CW'(1))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (st_ovf && count == CW'(DEPTH))); // R9

  AST_SYM_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (sym_len != 7'd0)); // R2

  AST_PKT_END: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> st_pend); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !push); // R7

  AST_AVAIL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (count > CW'(ien_lvl)) |=> st_avail); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_bits == 3'b000) |-> !irq); // R11
endmodule

bind cir_rx_top cir_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_i), .run(run), .push(coder_push), .pop(fifo_pop),
  .full(fifo_full), .pkt_end(pkt_end), .count(fifo_count), .sym_len(coder_sym.len),
  .st_ovf(st_ovf), .st_pend(st_pend), .st_avail(st_avail),
  .ien_bits({ien_avail, ien_pend, ien_ovf}), .ien_lvl(ien_lvl), .irq(irq));

// File: tb/test_cir_rx_top.sv
module test_cir_rx_top;
  import cir_rx_pkg::*;
  localparam int DEPTH = 16;

  logic        clk = 1'b0, rst_n = 1'b0, ir_in = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire         irq;

  int total = 0, bad = 0, inv = 0, per = 64;
  int run_lvl[$], run_len[$], exp_q[$];

  always #10 clk = ~clk;

  cir_rx_top #(.DEPTH(DEPTH), .BASE_DIV(1)) i_cir_rx_top (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic add(input int l, input int n);
    run_lvl.push_back(l); run_len.push_back(n);
  endtask

  task automatic play();
    foreach (run_lvl[i]) begin
      ir_in = run_lvl[i][0] ^ inv[0];
      repeat (run_len[i] * per) @(negedge clk);
    end
  endtask

  // behavioural reference: merge short runs, split long ones, stop at idle limit
  task automatic build_expect(input int f, input int t);
    int ml[$], mn[$];
    exp_q.delete();
    foreach (run_lvl[i]) begin
      if (ml.size() > 0 && (run_len[i] < f || ml[ml.size()-1] == run_lvl[i]))
        mn[mn.size()-1] = mn[mn.size()-1] + run_len[i];
      else begin
        ml.push_back(run_lvl[i]); mn.push_back(run_len[i]);
      end
    end
    foreach (ml[k]) begin
      if (k == ml.size() - 1 && ml[k] == 0) begin
        for (int m = 0; m < (t - 2) / 127; m++) exp_q.push_back(127);
      end else begin
        int len = mn[k];
        while (len > 127) begin
          exp_q.push_back((ml[k] << 7) | 127); len -= 127;
        end
        exp_q.push_back((ml[k] << 7) | len);
      end
    end
  endtask

  task automatic configure(input int div, input int filt, input int idle,
                           input int invert, input int ien, input int ctrl);
    wr(A_CTRL, 0);
    wr(A_SCFG, (idle << 8) | (filt << 2) | div);
    inv = invert; ir_in = inv[0]; per = div ? 128 : 64;
    wr(A_RXCFG, invert << 2);
    wr(A_IEN, ien);
    wr(A_STAT, 'hff);
    repeat (4) @(negedge clk);
    wr(A_CTRL, ctrl);
    run_lvl.delete(); run_len.delete();
  endtask

  task automatic pop_cmp(input string req, input int from, input int n);
    int d;
    for (int i = from; i < from + n; i++) begin
      rd(A_DATA, d);
      chk(req, d, exp_q[i]);
    end
  endtask

  task automatic check_packet(input string req, input int f, input int t);
    int s;
    build_expect(f, t);
    rd(A_STAT, s);
    chk({req, " packet end"}, (s >> 1) & 1, 1);
    chk({req, " count"}, (s >> 8) & 31, exp_q.size());
    pop_cmp(req, 0, exp_q.size());
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), s);
      chk($sformatf("R1 reg %0d", a), s, 0);
    end
    chk("R1 irq", irq, 0);

    // R2 R5 R8 R11: basic packet at /128
    configure(1, 0, 0, 0, 'h2, 'h33);
    add(1, 5); add(0, 3); add(1, 2); add(0, 7); add(1, 1); add(0, 200);
    play();
    chk("R11 irq on packet end", irq, 1);
    check_packet("R2", 0, 128);
    rd(A_DATA, s);
    chk("R8 empty pop", s, 0);
    rd(A_STAT, s);
    chk("R10 avail sticky", (s >> 4) & 1, 1);
    wr(A_STAT, 'h12);
    rd(A_STAT, s);
    chk("R10 cleared", s & 'h13, 0);
    chk("R11 irq clear", irq, 0);

    // R4: glitch filter
    configure(0, 3, 0, 0, 0, 'h33);
    add(1, 6); add(0, 2); add(1, 4); add(0, 5); add(1, 1); add(0, 6); add(1, 3); add(0, 150);
    play();
    check_packet("R4", 3, 128);

    // R6: inverted input
    configure(0, 0, 0, 1, 0, 'h33);
    add(1, 4); add(0, 4); add(1, 4); add(0, 140);
    play();
    check_packet("R6", 0, 128);

    // R7: wrong mode, no capture
    configure(0, 0, 0, 0, 0, 'h13);
    add(1, 3); add(0, 3); add(1, 3); add(0, 140);
    play();
    rd(A_STAT, s);
    chk("R7 count", (s >> 8) & 31, 0);
    chk("R7 packet end", (s >> 1) & 1, 0);

    // R9 R10: overflow and level boundary
    configure(0, 0, 0, 0, 'h11 | (3 << 8), 'h33);
    for (int i = 0; i < 11; i++) begin add(1, 2); add(0, 2); end
    add(1, 2); add(0, 140);
    play();
    build_expect(0, 128);
    rd(A_STAT, s);
    chk("R9 overflow", s & 1, 1);
    chk("R8 full count", (s >> 8) & 31, DEPTH);
    chk("R10 avail", (s >> 4) & 1, 1);
    chk("R11 irq", irq, 1);
    pop_cmp("R9", 0, DEPTH - 3);
    wr(A_STAT, 'h10);
    rd(A_STAT, s);
    chk("R10 at level", (s >> 4) & 1, 0);
    chk("R10 count at level", (s >> 8) & 31, 3);
    pop_cmp("R9", DEPTH - 3, 3);
    wr(A_STAT, 'h01);
    rd(A_STAT, s);
    chk("R9 overflow cleared", s & 1, 0);
    chk("R11 irq low", irq, 0);

    // R3 R5: long runs, idle limit 256 samples
    configure(0, 0, 1, 0, 0, 'h33);
    add(1, 130); add(0, 254); add(1, 3); add(0, 300);
    play();
    check_packet("R3", 0, 256);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule